// File: doc/BRIEF.md
# Saturating Multiply-Accumulate Unit

This block multiplies two signed operands and adds the product into a 64-bit accumulator held as two 32-bit halves. The high half supplies bits 63:32 and the low half supplies bits 31:0. A mode select input chooses the operation. The narrow (word) operation multiplies the sign-extended low 16 bits of each operand. The wide (long) operation multiplies the full signed 32-bit operands.

A saturation enable input selects how the new total is clamped, and the rule depends on the operation:
- The word operation clamps the total to the signed 32-bit range in the low half. It writes the value 1 to the high half as an overflow marker.
- The long operation clamps the total to the signed 48-bit range.
- With saturation off, the full 64-bit two's-complement total is kept.

An operation is issued with a one-cycle start strobe and completes two clock edges later with a one-cycle done strobe. Operations may be issued on every cycle. Software-style access to the accumulator goes through a synchronous clear and through per-half load strobes that share one data bus. Both halves are always visible on the read ports.

Top module: `mac_sat_top`

## Requirements
- R1: After reset both accumulator halves read 0 and done is 0. The accumulator value is {acc_hi, acc_lo} as a signed 64-bit number.
- R2: With op_long=0 (word), only bits 15:0 of each operand are used, sign-extended. Bits 31:16 have no effect on the result.
- R3: With op_long=1 (long), both 32-bit operands are taken as signed, and the 64-bit signed product is added to the accumulator.
- R4: With sat_en=0, either operation stores the 64-bit two's-complement sum, wrapping on overflow.
- R5: Word with sat_en=1 and a sum below -2^31 gives acc_lo=0x80000000. A sum above 2^31-1 gives acc_lo=0x7FFFFFFF. In both clamp cases acc_hi=0x00000001. An in-range sum is stored unchanged.
- R6: Long with sat_en=1 and a sum below -2^47 gives {acc_hi,acc_lo}=0xFFFF8000_00000000. A sum above 2^47-1 gives 0x00007FFF_FFFFFFFF. An in-range sum is stored unchanged.
- R7: When start is sampled at clock edge k, the accumulator and done update at edge k+1. done is high for exactly one cycle. A start on every cycle yields a done on every cycle, and each operation accumulates onto the result of the one before it.
- R8: When acc_clr is sampled, both halves become 0 at that edge. This has priority over a start and over a load in the same cycle. The clear cancels that start and any operation in flight, so no done follows for them.
- R9: load_hi and load_lo write load_data into the selected half or halves at the sampled edge. A load also cancels a start in the same cycle and any operation in flight.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| start | input | 1 | Issue one operation |
| op_long | input | 1 | 0: word (16x16) operation, 1: long (32x32) operation |
| sat_en | input | 1 | Saturation enable for the issued operation |
| opa | input | 32 | First operand |
| opb | input | 32 | Second operand |
| acc_clr | input | 1 | Synchronous clear of both halves |
| load_hi | input | 1 | Write load_data into the high half |
| load_lo | input | 1 | Write load_data into the low half |
| load_data | input | 32 | Data for the half loads |
| done | output | 1 | One-cycle completion strobe |
| acc_hi | output | 32 | Accumulator bits 63:32 |
| acc_lo | output | 32 | Accumulator bits 31:0 |

## Verification
The registered product is kept only in the pipeline, so a bad product or a wrong clamp branch first appears on acc_hi/acc_lo in the cycle that done rises, one edge after the product is captured. A lost or stale pipeline valid shows up within two edges as a missing done, a doubled done, or a done that follows a clear. An error in the accumulator register itself persists and is carried into every later sum, so back-to-back operations and read-back after loads expose it.

// File: rtl/mac_sat_pkg.sv
package mac_sat_pkg;
  localparam int unsigned WORD_W = 32;
  localparam int unsigned HALF_W = 16;
  localparam int unsigned ACC_W  = 2 * WORD_W;
  localparam int unsigned SAT_LONG_W = 48;

  typedef enum logic {
    OP_WORD = 1'b0,
    OP_LONG = 1'b1
  } mac_op_e;

  typedef struct packed {
    mac_op_e op;
    logic    sat;
  } mac_ctl_t;
endpackage

// File: rtl/mac_mul_stage.sv
module mac_mul_stage
  import mac_sat_pkg::*;
#(
  parameter int unsigned DW = WORD_W,
  parameter int unsigned NW = HALF_W,
  localparam int unsigned PW = 2 * DW
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 start_i,
  input  logic                 kill_i,
  input  mac_ctl_t             ctl_i,
  input  logic [DW-1:0]        opa_i,
  input  logic [DW-1:0]        opb_i,
  output logic                 vld_o,
  output mac_ctl_t             ctl_o,
  output logic signed [PW-1:0] prod_o
);
  logic signed [DW-1:0] a_ext, b_ext;
  logic signed [PW-1:0] a_wide, b_wide;
  logic signed [PW-1:0] prod_d;
  logic                 vld_d;
  logic                 cap_en;

  always_comb begin
    if (ctl_i.op == OP_LONG) begin
      a_ext = opa_i;
      b_ext = opb_i;
    end else begin
      a_ext = {{(DW-NW){opa_i[NW-1]}}, opa_i[NW-1:0]};
      b_ext = {{(DW-NW){opb_i[NW-1]}}, opb_i[NW-1:0]};
    end
    a_wide = {{DW{a_ext[DW-1]}}, a_ext};
    b_wide = {{DW{b_ext[DW-1]}}, b_ext};
    prod_d = a_wide * b_wide;
    cap_en = start_i & ~kill_i;
    vld_d  = cap_en;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_o <= 1'b0;
    end else begin
      vld_o <= vld_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl_o  <= '0;
      prod_o <= '0;
    end else if (cap_en) begin
      ctl_o  <= ctl_i;
      prod_o <= prod_d;
    end
  end
endmodule

// File: rtl/mac_sat_unit.sv
module mac_sat_unit
  import mac_sat_pkg::*;
#(
  parameter int unsigned DW  = WORD_W,
  parameter int unsigned LSW = SAT_LONG_W,
  localparam int unsigned PW = 2 * DW,
  localparam int unsigned SW = PW + 1
) (
  input  logic [DW-1:0]        hi_i,
  input  logic [DW-1:0]        lo_i,
  input  logic signed [PW-1:0] prod_i,
  input  mac_ctl_t             ctl_i,
  output logic [DW-1:0]        hi_o,
  output logic [DW-1:0]        lo_o
);
  localparam logic signed [SW-1:0] ONE    = SW'(1);
  localparam logic signed [SW-1:0] W_MAX  = (ONE <<< (DW - 1)) - ONE;
  localparam logic signed [SW-1:0] W_MIN  = -(ONE <<< (DW - 1));
  localparam logic signed [SW-1:0] L_MAX  = (ONE <<< (LSW - 1)) - ONE;
  localparam logic signed [SW-1:0] L_MIN  = -(ONE <<< (LSW - 1));

  logic signed [SW-1:0] acc_ext, prod_ext, sum;
  logic                 over_hi, over_lo;
  logic signed [SW-1:0] hi_bound, lo_bound;

  always_comb begin
    acc_ext  = {hi_i[DW-1], hi_i, lo_i};
    prod_ext = {prod_i[PW-1], prod_i};
    sum      = acc_ext + prod_ext;

    if (ctl_i.op == OP_LONG) begin
      hi_bound = L_MAX;
      lo_bound = L_MIN;
    end else begin
      hi_bound = W_MAX;
      lo_bound = W_MIN;
    end
    over_hi = ctl_i.sat && (sum > hi_bound);
    over_lo = ctl_i.sat && (sum < lo_bound);

    hi_o = sum[PW-1:DW];
    lo_o = sum[DW-1:0];
    if (over_hi || over_lo) begin
      if (ctl_i.op == OP_LONG) begin
        hi_o = over_hi ? L_MAX[PW-1:DW] : L_MIN[PW-1:DW];
        lo_o = over_hi ? L_MAX[DW-1:0]  : L_MIN[DW-1:0];
      end else begin
        hi_o = DW'(1);
        lo_o = over_hi ? W_MAX[DW-1:0] : W_MIN[DW-1:0];
      end
    end
  end
endmodule

// File: rtl/mac_acc_reg.sv
module mac_acc_reg
  import mac_sat_pkg::*;
#(
  parameter int unsigned DW = WORD_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr_i,
  input  logic          ld_hi_i,
  input  logic          ld_lo_i,
  input  logic [DW-1:0] ld_data_i,
  input  logic          wr_en_i,
  input  logic [DW-1:0] wr_hi_i,
  input  logic [DW-1:0] wr_lo_i,
  output logic [DW-1:0] hi_o,
  output logic [DW-1:0] lo_o
);
  logic [DW-1:0] hi_d, lo_d;
  logic          upd_en;

  always_comb begin
    hi_d   = hi_o;
    lo_d   = lo_o;
    upd_en = clr_i | ld_hi_i | ld_lo_i | wr_en_i;
    if (clr_i) begin
      hi_d = '0;
      lo_d = '0;
    end else if (ld_hi_i || ld_lo_i) begin
      if (ld_hi_i) hi_d = ld_data_i;
      if (ld_lo_i) lo_d = ld_data_i;
    end else if (wr_en_i) begin
      hi_d = wr_hi_i;
      lo_d = wr_lo_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hi_o <= '0;
      lo_o <= '0;
    end else if (upd_en) begin
      hi_o <= hi_d;
      lo_o <= lo_d;
    end
  end

  // R8: clear zeroes both halves at the next edge
  a_r8_clear_zeroes: assert property (@(posedge clk) disable iff (!rst_n)
    clr_i |=> (hi_o == '0 && lo_o == '0));

  // R9: a load of one half leaves the other half untouched
  a_r9_load_hi_only: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr_i && ld_hi_i && !ld_lo_i) |=> (hi_o == $past(ld_data_i) && $stable(lo_o)));
endmodule

// File: rtl/mac_sat_top.sv
module mac_sat_top
  import mac_sat_pkg::*;
#(
  parameter int unsigned DW  = WORD_W,
  parameter int unsigned NW  = HALF_W,
  parameter int unsigned LSW = SAT_LONG_W,
  localparam int unsigned PW = 2 * DW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic          op_long,
  input  logic          sat_en,
  input  logic [DW-1:0] opa,
  input  logic [DW-1:0] opb,
  input  logic          acc_clr,
  input  logic          load_hi,
  input  logic          load_lo,
  input  logic [DW-1:0] load_data,
  output logic          done,
  output logic [DW-1:0] acc_hi,
  output logic [DW-1:0] acc_lo
);
  logic                 rst_meta, rst_sync_n;
  logic                 kill;
  mac_ctl_t             ctl_in, ctl_q;
  logic                 vld_q;
  logic signed [PW-1:0] prod_q;
  logic [DW-1:0]        new_hi, new_lo;
  logic                 wr_en;
  logic                 done_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta   <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta   <= 1'b1;
      rst_sync_n <= rst_meta;
    end
  end

  always_comb begin
    kill      = acc_clr | load_hi | load_lo;
    ctl_in.op = op_long ? OP_LONG : OP_WORD;
    ctl_in.sat = sat_en;
    wr_en     = vld_q & ~kill;
    done_d    = wr_en;
  end

  mac_mul_stage #(.DW(DW), .NW(NW)) mul_i (
    .clk    (clk),
    .rst_n  (rst_sync_n),
    .start_i(start),
    .kill_i (kill),
    .ctl_i  (ctl_in),
    .opa_i  (opa),
    .opb_i  (opb),
    .vld_o  (vld_q),
    .ctl_o  (ctl_q),
    .prod_o (prod_q)
  );

  mac_sat_unit #(.DW(DW), .LSW(LSW)) sat_i (
    .hi_i  (acc_hi),
    .lo_i  (acc_lo),
    .prod_i(prod_q),
    .ctl_i (ctl_q),
    .hi_o  (new_hi),
    .lo_o  (new_lo)
  );

  mac_acc_reg #(.DW(DW)) acc_i (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .clr_i    (acc_clr),
    .ld_hi_i  (load_hi),
    .ld_lo_i  (load_lo),
    .ld_data_i(load_data),
    .wr_en_i  (wr_en),
    .wr_hi_i  (new_hi),
    .wr_lo_i  (new_lo),
    .hi_o     (acc_hi),
    .lo_o     (acc_lo)
  );

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      done <= 1'b0;
    end else begin
      done <= done_d;
    end
  end

  // R7: an uncancelled start produces done two edges later
  a_r7_done_latency: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (start && !kill) ##1 !kill |=> done);

  // R8: no done without a start two cycles earlier
  a_r8_no_spurious_done: assert property (@(posedge clk) disable iff (!rst_sync_n)
    done |-> $past(start, 2));

  // R5: saturated word result is 32-bit in range or a marked clamp
  a_r5_word_sat_range: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (wr_en && ctl_q.op == OP_WORD && ctl_q.sat) |=>
      ((acc_hi == {DW{acc_lo[DW-1]}}) ||
       (acc_hi == DW'(1) && (acc_lo == {1'b0, {(DW-1){1'b1}}} || acc_lo == {1'b1, {(DW-1){1'b0}}}))));

  // R6: saturated long result keeps the high half inside the 48-bit range
  a_r6_long_sat_range: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (wr_en && ctl_q.op == OP_LONG && ctl_q.sat) |=>
      ((acc_hi[DW-1:LSW-DW-1] == '0) || (acc_hi[DW-1:LSW-DW-1] == '1)));
endmodule

// File: tb/mac_sat_top_tb.sv
`timescale 1ns/1ps
module mac_sat_top_tb_top;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        start, op_long, sat_en, acc_clr, load_hi, load_lo;
  logic [31:0] opa, opb, load_data;
  logic        done;
  logic [31:0] acc_hi, acc_lo;
  int          n_checks = 0;
  int          n_errors = 0;
  logic [63:0] model_acc;

  always #2.5 clk = ~clk;

  mac_sat_top dut_i (
    .clk(clk), .rst_n(rst_n), .start(start), .op_long(op_long), .sat_en(sat_en),
    .opa(opa), .opb(opb), .acc_clr(acc_clr), .load_hi(load_hi), .load_lo(load_lo),
    .load_data(load_data), .done(done), .acc_hi(acc_hi), .acc_lo(acc_lo)
  );

  function automatic logic [63:0] model(logic [63:0] acc, logic lng, logic [31:0] a,
                                        logic [31:0] b, logic s);
    logic signed [31:0] as_, bs_;
    logic signed [64:0] ae, be, p, sm;
    as_ = lng ? a : {{16{a[15]}}, a[15:0]};
    bs_ = lng ? b : {{16{b[15]}}, b[15:0]};
    ae  = {{33{as_[31]}}, as_};
    be  = {{33{bs_[31]}}, bs_};
    p   = ae * be;
    sm  = {acc[63], acc} + p;
    if (s && !lng) begin
      if (sm > 65'sh0_7FFF_FFFF)       return 64'h00000001_7FFFFFFF;
      if (sm < -65'sh0_8000_0000)      return 64'h00000001_80000000;
    end else if (s && lng) begin
      if (sm > 65'sh0_7FFF_FFFF_FFFF)  return 64'h00007FFF_FFFFFFFF;
      if (sm < -65'sh0_8000_0000_0000) return 64'hFFFF8000_00000000;
    end
    return sm[63:0];
  endfunction

  task automatic chk(input logic ok, input string tag, input logic [63:0] act,
                     input logic [63:0] exp);
    n_checks++;
    if (!ok) begin
      n_errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic chk_acc(input string tag);
    chk({acc_hi, acc_lo} == model_acc, tag, {acc_hi, acc_lo}, model_acc);
  endtask

  task automatic idle_inputs();
    start = 0; op_long = 0; sat_en = 0; acc_clr = 0; load_hi = 0; load_lo = 0;
    opa = '0; opb = '0; load_data = '0;
  endtask

  task automatic load_acc(input logic [63:0] v);
    @(negedge clk);
    load_hi = 1; load_lo = 1; load_data = v[63:32];
    @(negedge clk);
    load_hi = 0; load_data = v[31:0];
    @(negedge clk);
    load_lo = 0;
    model_acc = v;
  endtask

  task automatic run_op(input string tag, input logic lng, input logic [31:0] a,
                        input logic [31:0] b, input logic s);
    @(negedge clk);
    start = 1; op_long = lng; opa = a; opb = b; sat_en = s;
    @(negedge clk);
    start = 0;
    chk(done == 1'b0, {tag, " R7 done early"}, 64'(done), 64'd0);
    @(negedge clk);
    chk(done == 1'b1, {tag, " R7 done"}, 64'(done), 64'd1);
    model_acc = model(model_acc, lng, a, b, s);
    chk_acc(tag);
    @(negedge clk);
    chk(done == 1'b0, {tag, " R7 done one cycle"}, 64'(done), 64'd0);
  endtask

  task automatic t_reset();
    model_acc = '0;
    chk_acc("R1 reset acc");
    chk(done == 1'b0, "R1 reset done", 64'(done), 64'd0);
  endtask

  task automatic t_word();
    load_acc(64'd0);
    run_op("R2 word upper ignored", 0, 32'hABCD_0003, 32'h1234_0004, 0);
    run_op("R2 word negative", 0, 32'h0000_FFFE, 32'h0000_0003, 0);
  endtask

  task automatic t_long();
    load_acc(64'd0);
    run_op("R3 long min*min", 1, 32'h8000_0000, 32'h8000_0000, 0);
    chk(model_acc == 64'h40000000_00000000, "R3 model", model_acc, 64'h40000000_00000000);
    run_op("R3 long signed", 1, 32'hFFFF_FFFF, 32'h0000_0005, 0);
  endtask

  task automatic t_wrap();
    load_acc(64'h7FFFFFFF_FFFFFFFF);
    run_op("R4 wrap long", 1, 32'd1, 32'd1, 0);
    chk(model_acc == 64'h80000000_00000000, "R4 model", model_acc, 64'h80000000_00000000);
    load_acc(64'h00000000_7FFF0000);
    run_op("R4 word no clamp", 0, 32'h7FFF, 32'h7FFF, 0);
  endtask

  task automatic t_word_sat();
    load_acc(64'h00000000_7FFF0000);
    run_op("R5 word sat pos", 0, 32'h7FFF, 32'h7FFF, 1);
    chk(model_acc == 64'h00000001_7FFFFFFF, "R5 pos value", model_acc, 64'h00000001_7FFFFFFF);
    load_acc(64'hFFFFFFFF_80000010);
    run_op("R5 word sat neg", 0, 32'h8000, 32'h0001, 1);
    load_acc(64'd100);
    run_op("R5 word in range", 0, 32'hFFF6, 32'd3, 1);
  endtask

  task automatic t_long_sat();
    load_acc(64'h00007FFF_FFFFFF00);
    run_op("R6 long sat pos", 1, 32'h0001_0000, 32'h0001_0000, 1);
    load_acc(64'hFFFF8000_00000100);
    run_op("R6 long sat neg", 1, 32'h8000_0000, 32'd1, 1);
    load_acc(64'd0);
    run_op("R6 long in range", 1, -32'sd5, 32'd7, 1);
  endtask

  task automatic t_back_to_back();
    load_acc(64'd10);
    @(negedge clk);
    start = 1; op_long = 0; opa = 32'd2; opb = 32'd3; sat_en = 0;
    @(negedge clk);
    op_long = 1; opa = 32'd4; opb = 32'd5;
    @(negedge clk);
    start = 0;
    chk(done == 1'b1, "R7 b2b first done", 64'(done), 64'd1);
    model_acc = model(model_acc, 0, 32'd2, 32'd3, 0);
    chk_acc("R7 b2b first");
    @(negedge clk);
    chk(done == 1'b1, "R7 b2b second done", 64'(done), 64'd1);
    model_acc = model(model_acc, 1, 32'd4, 32'd5, 0);
    chk_acc("R7 b2b second");
  endtask

  task automatic t_clear();
    load_acc(64'h12345678_9ABCDEF0);
    @(negedge clk);
    start = 1; acc_clr = 1; load_hi = 1; load_data = 32'hDEAD_BEEF;
    opa = 32'd7; opb = 32'd7; op_long = 1;
    @(negedge clk);
    start = 0; acc_clr = 0; load_hi = 0;
    model_acc = '0;
    chk_acc("R8 clear over start and load");
    @(negedge clk);
    chk(done == 1'b0, "R8 no done after clear", 64'(done), 64'd0);
    chk_acc("R8 acc stays zero");
    load_acc(64'd5);
    @(negedge clk);
    start = 1; opa = 32'd9; opb = 32'd9;
    @(negedge clk);
    start = 0; acc_clr = 1;
    @(negedge clk);
    acc_clr = 0;
    chk(done == 1'b0, "R8 in-flight cancelled", 64'(done), 64'd0);
    model_acc = '0;
    chk_acc("R8 in-flight clear");
  endtask

  task automatic t_load();
    load_acc(64'h0);
    @(negedge clk);
    load_hi = 1; load_data = 32'hCAFE_0001;
    @(negedge clk);
    load_hi = 0;
    model_acc = 64'hCAFE0001_00000000;
    chk_acc("R9 load hi only");
    @(negedge clk);
    start = 1; op_long = 1; opa = 32'd3; opb = 32'd3; load_lo = 1; load_data = 32'h55;
    @(negedge clk);
    start = 0; load_lo = 0;
    model_acc = 64'hCAFE0001_00000055;
    chk_acc("R9 load lo");
    @(negedge clk);
    chk(done == 1'b0, "R9 load cancels start", 64'(done), 64'd0);
    chk_acc("R9 acc after cancel");
  endtask

  initial begin
    idle_inputs();
    rst_n = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (3) @(negedge clk);
    t_reset();
    t_word();
    t_long();
    t_wrap();
    t_word_sat();
    t_long_sat();
    t_back_to_back();
    t_clear();
    t_load();
    repeat (2) @(negedge clk);
    $display("CHECKS %0d ERRORS %0d", n_checks, n_errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_checks++;
    n_errors++;
    $display("FAIL watchdog R7 actual=%h expected=%h", 64'd0, 64'd1);
    $display("CHECKS %0d ERRORS %0d", n_checks, n_errors);
    $finish;
  end
endmodule